// File: doc/BRIEF.md
# PWM Timer/Counter

This block is a 32-bit counter paired with two compare registers. Software reaches the registers through a 32-bit WISHBONE slave port. The counter drives a PWM output with a separate output-driver enable, and it can raise an interrupt request. On each system clock the counter either advances or holds. What makes it advance depends on the external pin mode:

- **Edge mode:** a synchronised edge of the external clock/gate pin advances it.
- **Gate mode:** the system clock advances it while the pin is at its non-blocking level.

A counting cycle ends when the counter equals the low reference. In continuous mode the counter then wraps to zero. In single-run mode it stays at that value.

Each compare register can also capture the live counter value. A rising edge on the capture pin loads the high register, and a falling edge loads the low register. This lets an external event define the PWM thresholds or record a time stamp. The PWM output rises after the counter meets the high reference and falls after it meets the low reference. The high reference should therefore be the smaller of the two.

Top module: `pwm_timer`

## Requirements
- R1: After reset, all four registers read zero, `pwmOen` is 1, and `pwmOut`, `irq` and `wbRty` are 0.
- R2: Word registers sit at these byte offsets: counter 0x0, high reference 0x4, low reference 0x8, control 0xC. Control bits 31..9 read as zero. A strobed cycle with `wbSel` = 0xF gets a one-cycle `wbAck` on the next clock. A written value reads back unchanged.
- R3: A strobed cycle with `wbSel` other than 0xF gets a one-cycle `wbErr` instead of `wbAck`, and the cycle changes no register.
- R4: With control bit 0 (run) set, bit 1 clear and the gate open, the counter advances once per clock. When it equals the low reference it wraps to 0, so the period is low+1 clocks. With bit 0 clear it holds.
- R5: `pwmOut` goes to 1 on the clock after the counter equals the high reference. It goes to 0 on the clock after the counter equals the low reference. The low match wins when both references are equal, so each period has low−high high cycles.
- R6: With control bit 4 (single-run) set, the counter stops once it equals the low reference.
- R7: While control bit 7 is set, the counter is held at 0 and `pwmOut` is 0.
- R8: With bit 1 clear, the synchronised pin blocks counting while it is high (bit 2 clear) or while it is low (bit 2 set). Each clock at the non-blocking level adds exactly one count.
- R9: With bit 1 set, each rising edge of the pin (bit 2 clear) or each falling edge (bit 2 set) adds one count.
- R10: With control bit 8 set, a rising edge of `captIn` copies the counter into the high register and a falling edge copies it into the low register. With bit 8 clear, `captIn` changes nothing.
- R11: With control bit 5 set, a count step that lands on either reference sets pending bit 6. While both bits are set, `irq` is 1. Writing 1 to bit 6 clears it. With bit 5 clear, pending stays 0.
- R12: `pwmOen` is the inverse of control bit 3.
- R13: A software write to the counter wins over a count step in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wbCyc | input | 1 | Bus cycle valid |
| wbStb | input | 1 | Transfer strobe |
| wbWe | input | 1 | Write when high |
| wbAdr | input | 2 | Word address (byte address bits 3..2) |
| wbDatIn | input | 32 | Write data |
| wbSel | input | 4 | Byte selects, must be 0xF |
| wbDatOut | output | 32 | Read data |
| wbAck | output | 1 | Normal termination |
| wbErr | output | 1 | Error termination |
| wbRty | output | 1 | Retry, always 0 |
| irq | output | 1 | Interrupt request |
| extClkGate | input | 1 | External count clock or gate |
| captIn | input | 1 | Capture input |
| pwmOut | output | 1 | PWM output |
| pwmOen | output | 1 | Output-driver enable, active low |

## Verification
The bus properties assume the master holds `wbCyc`/`wbStb` for exactly one clock and then leaves at least one idle clock before the next access. The directed tasks drive every access through a single bus task that keeps to this pattern.

The single-run hold property assumes no bus write lands in the same clock. The stimulus only writes the counter or control register while the counter is away from its stop point, or in tests where it cannot move.

External pin and capture changes are applied on falling clock edges and held for several clocks. Every edge therefore passes through the two-flop synchroniser cleanly, and the expected counts can be computed from the number of clocks the pin was held.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;

  localparam int CTRL_W = 9;

  // Word indices decoded from byte address bits 3..2
  localparam logic [1:0] IDX_CNT  = 2'd0;
  localparam logic [1:0] IDX_HI   = 2'd1;
  localparam logic [1:0] IDX_LO   = 2'd2;
  localparam logic [1:0] IDX_CTRL = 2'd3;

  localparam int PEND_BIT = 6;

  // Control register, MSB first so that bit positions match the map
  typedef struct packed {
    logic capEn;    // 8
    logic cntClr;   // 7
    logic pend;     // 6
    logic irqEn;    // 5
    logic oneShot;  // 4
    logic outEn;    // 3
    logic negPol;   // 2
    logic extClk;   // 1
    logic run;      // 0
  } ctrlBits_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntWr;
    logic hiWr;
    logic loWr;
    logic step;
    logic wrap;
    logic capHi;
    logic capLo;
  } dpStrobe_t;

endpackage

// File: rtl/pwmt_sync.sv
`timescale 1ns/1ps
module pwmt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= {stage[STAGES-2:0], asyncIn};
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/pwmt_datapath.sv
`timescale 1ns/1ps
module pwmt_datapath
  import pwmt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] hiVal,
  output logic [DATA_W-1:0] loVal,
  output logic              atLow,
  output logic              hitRef,
  output logic              pwmOut
);

  logic [DATA_W-1:0] cntQ, hiQ, loQ, stepVal;
  logic              pwmQ;

  assign atLow   = (cntQ == loQ);
  assign stepVal = (atLow && strobes.wrap) ? '0 : cntQ + 1'b1;
  assign hitRef  = strobes.step && !strobes.cntWr && ((stepVal == hiQ) || (stepVal == loQ));

  always_ff @(posedge clk) begin
    if (rst)                cntQ <= '0;
    else if (strobes.cntClr) cntQ <= '0;
    else if (strobes.cntWr)  cntQ <= wrData;
    else if (strobes.step)   cntQ <= stepVal;
  end

  always_ff @(posedge clk) begin
    if (rst)                hiQ <= '0;
    else if (strobes.hiWr)  hiQ <= wrData;
    else if (strobes.capHi) hiQ <= cntQ;
  end

  always_ff @(posedge clk) begin
    if (rst)                loQ <= '0;
    else if (strobes.loWr)  loQ <= wrData;
    else if (strobes.capLo) loQ <= cntQ;
  end

  // Low match has priority over high match
  always_ff @(posedge clk) begin
    if (rst)                 pwmQ <= 1'b0;
    else if (strobes.cntClr) pwmQ <= 1'b0;
    else if (cntQ == loQ)    pwmQ <= 1'b0;
    else if (cntQ == hiQ)    pwmQ <= 1'b1;
  end

  assign cntVal = cntQ;
  assign hiVal  = hiQ;
  assign loVal  = loQ;
  assign pwmOut = pwmQ;

endmodule

// File: rtl/pwmt_ctrl.sv
`timescale 1ns/1ps
module pwmt_ctrl
  import pwmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:2] wbAdr,
  input  logic [CTRL_W-1:0] wrBits,
  input  logic [3:0]        wbSel,
  output logic [DATA_W-1:0] wbDatOut,
  output logic              wbAck,
  output logic              wbErr,
  input  logic [DATA_W-1:0] cntVal,
  input  logic [DATA_W-1:0] hiVal,
  input  logic [DATA_W-1:0] loVal,
  input  logic              atLow,
  input  logic              hitRef,
  input  logic              extLevel,
  input  logic              captLevel,
  output ctrlBits_t         ctrlBits,
  output dpStrobe_t         strobes
);

  localparam int IDX_W = ADDR_W - 2;

  logic              req, access, wrAcc;
  logic [IDX_W-1:0]  idx;
  logic              selCnt, selHi, selLo, selCtrl;
  logic              ackQ, errQ;
  logic [DATA_W-1:0] rdMux, rdQ;
  ctrlBits_t         ctrlQ;
  logic              extPrev, captPrev;
  logic              extRise, extFall, captRise, captFall;
  logic              gateOpen, tick;

  // Bus handshake: one-cycle response to a freshly presented strobe
  assign req    = wbCyc && wbStb && !ackQ && !errQ;
  assign access = req && (wbSel == 4'hF);
  assign wrAcc  = access && wbWe;
  assign idx    = wbAdr;

  assign selCnt  = (idx == IDX_W'(IDX_CNT));
  assign selHi   = (idx == IDX_W'(IDX_HI));
  assign selLo   = (idx == IDX_W'(IDX_LO));
  assign selCtrl = (idx == IDX_W'(IDX_CTRL));

  always_comb begin
    rdMux = '0;
    if (selCnt)  rdMux = cntVal;
    if (selHi)   rdMux = hiVal;
    if (selLo)   rdMux = loVal;
    if (selCtrl) rdMux = {{(DATA_W-CTRL_W){1'b0}}, ctrlQ};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackQ <= 1'b0;
      errQ <= 1'b0;
      rdQ  <= '0;
    end else begin
      ackQ <= access;
      errQ <= req && (wbSel != 4'hF);
      if (access) rdQ <= rdMux;
    end
  end

  // Control register; pending bit is set by hardware, cleared by writing 1
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ <= '0;
    end else begin
      if (wrAcc && selCtrl) begin
        ctrlQ <= ctrlBits_t'(wrBits);
        ctrlQ.pend <= ctrlQ.pend && !wrBits[PEND_BIT];
      end
      if (hitRef && ctrlQ.irqEn) ctrlQ.pend <= 1'b1;
    end
  end

  // Edge detection on synchronised pins
  always_ff @(posedge clk) begin
    if (rst) begin
      extPrev  <= 1'b0;
      captPrev <= 1'b0;
    end else begin
      extPrev  <= extLevel;
      captPrev <= captLevel;
    end
  end

  assign extRise  = extLevel && !extPrev;
  assign extFall  = !extLevel && extPrev;
  assign captRise = captLevel && !captPrev;
  assign captFall = !captLevel && captPrev;

  // Count qualification
  assign gateOpen = ctrlQ.negPol ? extLevel : !extLevel;
  assign tick     = ctrlQ.extClk ? (ctrlQ.negPol ? extFall : extRise) : gateOpen;

  always_comb begin
    strobes        = '0;
    strobes.cntClr = ctrlQ.cntClr;
    strobes.cntWr  = wrAcc && selCnt;
    strobes.hiWr   = wrAcc && selHi;
    strobes.loWr   = wrAcc && selLo;
    strobes.step   = ctrlQ.run && !ctrlQ.cntClr && !(ctrlQ.oneShot && atLow) && tick;
    strobes.wrap   = !ctrlQ.oneShot;
    strobes.capHi  = ctrlQ.capEn && captRise;
    strobes.capLo  = ctrlQ.capEn && captFall;
  end

  assign ctrlBits = ctrlQ;
  assign wbAck    = ackQ;
  assign wbErr    = errQ;
  assign wbDatOut = rdQ;

endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
  import pwmt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:2] wbAdr,
  input  logic [DATA_W-1:0] wbDatIn,
  input  logic [3:0]        wbSel,
  output logic [DATA_W-1:0] wbDatOut,
  output logic              wbAck,
  output logic              wbErr,
  output logic              wbRty,
  output logic              irq,
  input  logic              extClkGate,
  input  logic              captIn,
  output logic              pwmOut,
  output logic              pwmOen
);

  logic [1:0]        syncLevel;
  logic [DATA_W-1:0] cntVal, hiVal, loVal;
  logic              atLow, hitRef;
  ctrlBits_t         ctrlBits;
  dpStrobe_t         strobes;

  pwmt_sync #(.W(2), .STAGES(SYNC_DEPTH)) uSync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({captIn, extClkGate}),
    .syncOut (syncLevel)
  );

  pwmt_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .wbCyc     (wbCyc),
    .wbStb     (wbStb),
    .wbWe      (wbWe),
    .wbAdr     (wbAdr),
    .wrBits    (wbDatIn[CTRL_W-1:0]),
    .wbSel     (wbSel),
    .wbDatOut  (wbDatOut),
    .wbAck     (wbAck),
    .wbErr     (wbErr),
    .cntVal    (cntVal),
    .hiVal     (hiVal),
    .loVal     (loVal),
    .atLow     (atLow),
    .hitRef    (hitRef),
    .extLevel  (syncLevel[0]),
    .captLevel (syncLevel[1]),
    .ctrlBits  (ctrlBits),
    .strobes   (strobes)
  );

  pwmt_datapath #(.DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (wbDatIn),
    .cntVal  (cntVal),
    .hiVal   (hiVal),
    .loVal   (loVal),
    .atLow   (atLow),
    .hitRef  (hitRef),
    .pwmOut  (pwmOut)
  );

  assign irq    = ctrlBits.pend && ctrlBits.irqEn;
  assign pwmOen = !ctrlBits.outEn;
  assign wbRty  = 1'b0;

endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
module pwm_timer_chk
  import pwmt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wbCyc,
  input logic              wbStb,
  input logic              wbWe,
  input logic [3:0]        wbSel,
  input logic              wbAck,
  input logic              wbErr,
  input logic              pwmOut,
  input logic [DATA_W-1:0] cntVal,
  input logic [DATA_W-1:0] loVal,
  input ctrlBits_t         ctrlBits
);

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    wbAck |=> !wbAck); // R2

  AST_ACK_GOOD_SEL: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !wbAck && !wbErr && wbSel == 4'hF) |=> wbAck); // R2

  AST_ERR_BAD_SEL: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !wbAck && !wbErr && wbSel != 4'hF) |=> (wbErr && !wbAck)); // R3

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    wbErr |=> !wbErr); // R3

  AST_CLR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctrlBits.cntClr |=> (cntVal == '0)); // R7

  AST_CLR_PWM_LOW: assert property (@(posedge clk) disable iff (rst)
    ctrlBits.cntClr |=> !pwmOut); // R7

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (ctrlBits.oneShot && !ctrlBits.cntClr && cntVal == loVal && !(wbCyc && wbStb && wbWe))
      |=> $stable(cntVal)); // R6

endmodule

bind pwm_timer pwm_timer_chk #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .wbCyc    (wbCyc),
  .wbStb    (wbStb),
  .wbWe     (wbWe),
  .wbSel    (wbSel),
  .wbAck    (wbAck),
  .wbErr    (wbErr),
  .pwmOut   (pwmOut),
  .cntVal   (cntVal),
  .loVal    (loVal),
  .ctrlBits (ctrlBits)
);

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
module sim_pwm_timer;

  localparam logic [1:0] A_CNT = 2'd0, A_HI = 2'd1, A_LO = 2'd2, A_CTRL = 2'd3;
  localparam logic [31:0] B_RUN = 32'h001, B_EXT = 32'h002, B_NEG = 32'h004,
                          B_OE  = 32'h008, B_ONE = 32'h010, B_IEN = 32'h020,
                          B_PND = 32'h040, B_CLR = 32'h080, B_CAP = 32'h100;

  logic        clk = 1'b0;
  logic        rst;
  logic        wbCyc, wbStb, wbWe;
  logic [3:2]  wbAdr;
  logic [31:0] wbDatIn;
  logic [3:0]  wbSel;
  logic [31:0] wbDatOut;
  logic        wbAck, wbErr, wbRty, irq;
  logic        extClkGate, captIn, pwmOut, pwmOen;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_timer u0 (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatIn(wbDatIn), .wbSel(wbSel), .wbDatOut(wbDatOut),
    .wbAck(wbAck), .wbErr(wbErr), .wbRty(wbRty), .irq(irq),
    .extClkGate(extClkGate), .captIn(captIn), .pwmOut(pwmOut), .pwmOen(pwmOen)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One access, one idle clock afterwards; called at a falling edge
  task automatic busXfer(input logic wr, input logic [1:0] a, input logic [31:0] d,
                         input logic [3:0] s, output logic [31:0] q,
                         output logic gotAck, output logic gotErr);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = wr; wbAdr = a; wbDatIn = d; wbSel = s;
    @(posedge clk);
    @(negedge clk);
    q = wbDatOut; gotAck = wbAck; gotErr = wbErr;
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] q; logic k, e;
    busXfer(1'b1, a, d, 4'hF, q, k, e);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] q);
    logic k, e;
    busXfer(1'b0, a, 32'h0, 4'hF, q, k, e);
  endtask

  task automatic rdChk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] q;
    rd(a, q);
    chk(tag, q, exp);
  endtask

  task automatic testReset;
    rdChk("R1 counter", A_CNT, 0);
    rdChk("R1 high ref", A_HI, 0);
    rdChk("R1 low ref", A_LO, 0);
    rdChk("R1 control", A_CTRL, 0);
    chk("R1 pwmOen", {31'b0, pwmOen}, 1);
    chk("R1 pwmOut", {31'b0, pwmOut}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wbRty", {31'b0, wbRty}, 0);
  endtask

  task automatic testRegs;
    logic [31:0] q; logic k, e;
    busXfer(1'b1, A_HI, 32'h1234_5678, 4'hF, q, k, e);
    chk("R2 ack on write", {30'b0, k, e}, 32'h2);
    rdChk("R2 high readback", A_HI, 32'h1234_5678);
    wr(A_LO, 32'hCAFE_F00D);
    rdChk("R2 low readback", A_LO, 32'hCAFE_F00D);
    wr(A_CTRL, 32'hFFFF_FE00);
    rdChk("R2 control upper bits zero", A_CTRL, 0);
    busXfer(1'b1, A_HI, 32'h0, 4'h3, q, k, e);
    chk("R3 err not ack", {30'b0, k, e}, 32'h1);
    rdChk("R3 high unchanged", A_HI, 32'h1234_5678);
    busXfer(1'b0, A_LO, 32'h0, 4'h1, q, k, e);
    chk("R3 read err", {30'b0, k, e}, 32'h1);
  endtask

  task automatic testContinuous;
    logic [31:0] a, b;
    int high, rises;
    logic prev;
    wr(A_CTRL, B_CLR);
    wr(A_HI, 2);
    wr(A_LO, 4);
    wr(A_CTRL, B_RUN | B_OE);
    chk("R12 oen low with bit3", {31'b0, pwmOen}, 0);
    waitCyc(10);
    high = 0; rises = 0; prev = pwmOut;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pwmOut) high++;
      if (pwmOut && !prev) rises++;
      prev = pwmOut;
    end
    chk("R5 high cycles in 10 periods", high, 20);
    chk("R4 periods of lo+1 clocks", rises, 10);
    wr(A_CTRL, B_OE);
    rd(A_CNT, a);
    waitCyc(5);
    rd(A_CNT, b);
    chk("R4 holds with run clear", b, a);
    wr(A_CTRL, 0);
    chk("R12 oen high with bit3 clear", {31'b0, pwmOen}, 1);
    wr(A_CTRL, B_CLR);
    wr(A_HI, 3);
    wr(A_LO, 3);
    wr(A_CTRL, B_RUN);
    high = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwmOut) high++;
    end
    chk("R5 equal refs keep pwm low", high, 0);
  endtask

  task automatic testSingleAndClear;
    wr(A_CTRL, B_CLR | B_RUN | B_ONE);
    wr(A_HI, 2);
    wr(A_LO, 6);
    rdChk("R7 counter held at zero", A_CNT, 0);
    wr(A_CTRL, B_RUN | B_ONE);
    waitCyc(20);
    rdChk("R6 stops at low ref", A_CNT, 6);
    waitCyc(10);
    rdChk("R6 still stopped", A_CNT, 6);
    chk("R5 pwm low after low match", {31'b0, pwmOut}, 0);
    wr(A_CTRL, B_CLR);
    wr(A_LO, 50);
    wr(A_CTRL, B_RUN);
    waitCyc(10);
    chk("R5 pwm high between refs", {31'b0, pwmOut}, 1);
    wr(A_CTRL, B_RUN | B_CLR);
    waitCyc(2);
    chk("R7 pwm low under clear", {31'b0, pwmOut}, 0);
    rdChk("R7 counter zero under clear", A_CNT, 0);
  endtask

  task automatic testWritePriority;
    wr(A_CTRL, B_CLR);
    wr(A_HI, 32'hFFFF_FFF0);
    wr(A_LO, 32'hFFFF_FFF0);
    wr(A_CTRL, B_RUN);
    waitCyc(3);
    wr(A_CNT, 100);
    rdChk("R13 write beats step", A_CNT, 101);
  endtask

  task automatic testGate;
    wr(A_CTRL, B_CLR);
    wr(A_HI, 500);
    wr(A_LO, 1000);
    extClkGate = 1'b1;
    waitCyc(5);
    wr(A_CTRL, B_RUN);
    waitCyc(10);
    rdChk("R8 high level blocks", A_CNT, 0);
    extClkGate = 1'b0;
    waitCyc(7);
    extClkGate = 1'b1;
    waitCyc(6);
    rdChk("R8 counts low clocks", A_CNT, 7);
    wr(A_CTRL, B_CLR | B_NEG);
    extClkGate = 1'b0;
    waitCyc(5);
    wr(A_CTRL, B_RUN | B_NEG);
    waitCyc(10);
    rdChk("R8 low level blocks with bit2", A_CNT, 0);
    extClkGate = 1'b1;
    waitCyc(4);
    extClkGate = 1'b0;
    waitCyc(6);
    rdChk("R8 counts high clocks with bit2", A_CNT, 4);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      extClkGate = 1'b1; waitCyc(4);
      extClkGate = 1'b0; waitCyc(4);
    end
  endtask

  task automatic testExtClock;
    extClkGate = 1'b0;
    wr(A_CTRL, B_CLR | B_EXT);
    wr(A_CTRL, B_RUN | B_EXT);
    waitCyc(10);
    rdChk("R9 no edges no count", A_CNT, 0);
    pulses(5);
    waitCyc(6);
    rdChk("R9 rising edges counted", A_CNT, 5);
    wr(A_CTRL, B_CLR | B_EXT | B_NEG);
    wr(A_CTRL, B_RUN | B_EXT | B_NEG);
    pulses(3);
    waitCyc(6);
    rdChk("R9 falling edges counted", A_CNT, 3);
  endtask

  task automatic testCapture;
    extClkGate = 1'b0;
    captIn = 1'b0;
    wr(A_CTRL, B_RUN | B_EXT | B_CAP);
    wr(A_CNT, 77);
    captIn = 1'b1;
    waitCyc(6);
    rdChk("R10 rise loads high", A_HI, 77);
    wr(A_CNT, 33);
    captIn = 1'b0;
    waitCyc(6);
    rdChk("R10 fall loads low", A_LO, 33);
    rdChk("R10 high untouched by fall", A_HI, 77);
    wr(A_CTRL, B_RUN | B_EXT);
    wr(A_CNT, 55);
    captIn = 1'b1;
    waitCyc(6);
    captIn = 1'b0;
    waitCyc(6);
    rdChk("R10 masked high", A_HI, 77);
    rdChk("R10 masked low", A_LO, 33);
  endtask

  task automatic testIrq;
    extClkGate = 1'b0;
    wr(A_CTRL, B_CLR);
    wr(A_HI, 3);
    wr(A_LO, 5);
    wr(A_CTRL, B_RUN | B_IEN);
    waitCyc(10);
    chk("R11 irq raised", {31'b0, irq}, 1);
    rdChk("R11 pending bit set", A_CTRL, B_RUN | B_IEN | B_PND);
    wr(A_CTRL, B_IEN);
    wr(A_CTRL, B_IEN | B_PND);
    rdChk("R11 pending cleared", A_CTRL, B_IEN);
    chk("R11 irq dropped", {31'b0, irq}, 0);
    wr(A_CTRL, B_CLR);
    wr(A_CTRL, B_RUN);
    waitCyc(20);
    chk("R11 masked irq", {31'b0, irq}, 0);
    rdChk("R11 masked pending stays 0", A_CTRL, B_RUN);
  endtask

  initial begin
    rst = 1'b1;
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0; wbAdr = '0; wbDatIn = '0; wbSel = 4'hF;
    extClkGate = 1'b0; captIn = 1'b0;
    waitCyc(3);
    rst = 1'b0;
    waitCyc(2);
    testReset();
    testRegs();
    testContinuous();
    testSingleAndClear();
    testWritePriority();
    testGate();
    testExtClock();
    testCapture();
    testIrq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule